// File: doc/BRIEF.md
# Streaming Transfer Data Buffer

This block holds the payload of one flash transfer chunk in a 512-byte store. Two agents share it. A host register port moves whole 32-bit words through a single data register. A serial sequencer moves single bytes. On the host side, a control word sets three things: the access direction, whether the word pointer steps on its own, and the pointer's starting value. With stepping on, the host streams a run of words through the one data register without reloading the pointer.

The sequencer has its own byte cursor. That cursor starts from a programmable byte offset, which software clears before each chunk. Each sequencer byte access moves the cursor forward by one. Bytes are packed little-endian inside each word.

A chunk whose length is not a whole number of words is finished by the host with one extra full-word access. Only the low bytes of that last word matter.

Top module: `xfer_buf`

## Requirements
- R1: After reset, `host_ptr` is 0, the mode is host-read with stepping off, the sequencer offset is 0, and both `dat_rvalid` and `seq_rvalid` are low.
- R2: A control write takes the mode from `ctl_wdata` bit 31 (1 = host writes into the buffer, 0 = host reads out). It takes stepping enable from bit 30. It loads the word pointer from bits 7..0 modulo the word count (with 128 words, 200 loads 72).
- R3: In write mode, `dat_wr` stores `dat_wdata` into the word at the pointer. In read mode, `dat_wr` changes neither the buffer nor the pointer.
- R4: In read mode, `dat_rd` returns the word at the pointer on `dat_rdata`, with `dat_rvalid` high in the following cycle. In write mode, `dat_rd` gives no `dat_rvalid` and does not move the pointer.
- R5: With stepping on, each accepted data access advances the pointer by one, and the last word wraps to word 0. With stepping off, the pointer holds.
- R6: A control write in the same cycle as a data strobe wins. The data strobe is dropped and the buffer is untouched.
- R7: `seq_ofs_wr` loads the 9-bit byte offset. `seq_start` loads the byte cursor from the offset. A sequencer access in the same cycle as `seq_start` is dropped.
- R8: `seq_rd` returns the byte at the cursor on `seq_rdata`, with `seq_rvalid` high in the next cycle, and advances the cursor. The cursor wraps from byte 511 to byte 0.
- R9: `seq_wr` stores `seq_wdata` at the cursor and advances it. When `seq_wr` and `seq_rd` are both high, the write is done and the read is dropped (no `seq_rvalid`).
- R10: Byte address b lies in word b/4, bits 8*(b%4)+7 down to 8*(b%4).
- R11: A host read of a final word that the sequencer only partly filled returns the new bytes in the low lanes and the earlier contents in the other lanes.
- R12: When a host word write and a sequencer byte write hit the same byte in the same cycle, the host value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Control word: mode, stepping, pointer |
| dat_wr | input | 1 | Host data write strobe |
| dat_wdata | input | 32 | Host write word |
| dat_rd | input | 1 | Host data read strobe |
| dat_rdata | output | 32 | Host read word |
| dat_rvalid | output | 1 | Host read word valid |
| host_ptr | output | 7 | Current host word pointer |
| seq_ofs_wr | input | 1 | Sequencer offset write strobe |
| seq_ofs | input | 9 | Sequencer start byte offset |
| seq_start | input | 1 | Load the cursor from the offset |
| seq_rd | input | 1 | Sequencer byte read strobe |
| seq_rdata | output | 8 | Sequencer read byte |
| seq_rvalid | output | 1 | Sequencer read byte valid |
| seq_wr | input | 1 | Sequencer byte write strobe |
| seq_wdata | input | 8 | Sequencer write byte |

## Verification
The bench uses the default sizes: 512 bytes, 4-byte words, so 128 words. At these sizes every word and every byte can be swept. A full host write pass and a full host read pass both cross the pointer wrap. A full 512-byte sequencer read pass, plus one more byte, crosses the cursor wrap. Offsets near the end of the buffer, a partly filled final word, and same-cycle collisions between strobes are all reached with a handful of directed cycles.

// File: rtl/xfer_buf_pkg.sv
package xfer_buf_pkg;
  // control word layout: mode and stepping bits are decoded by the host port
  localparam int CTL_MODE_BIT = 31;  // 1: host writes, 0: host reads
  localparam int CTL_STEP_BIT = 30;  // pointer steps after each access
  localparam int CTL_PTR_MSB  = 7;   // pointer field is bits 7..0

  typedef struct packed {
    logic wr_mode;
    logic step;
  } host_mode_t;
endpackage

// File: rtl/xfer_buf_lane.sv
module xfer_buf_lane #(
  parameter int DEPTH = 128,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          a_en,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [7:0]    a_din,
  output logic [7:0]    a_dout,
  input  logic          b_en,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [7:0]    b_din,
  output logic [7:0]    b_dout
);
  logic [7:0] mem [DEPTH];

  // port B written first so a same-address host write lands last
  always_ff @(posedge clk) begin
    if (b_we) mem[b_addr] <= b_din;
    if (a_we) mem[a_addr] <= a_din;
    if (a_en) a_dout <= mem[a_addr];
    if (b_en) b_dout <= mem[b_addr];
  end
endmodule

// File: rtl/xfer_buf_host.sv
module xfer_buf_host
  import xfer_buf_pkg::*;
#(
  parameter int WORDS = 128,
  parameter int PTR_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_wr,
  input  host_mode_t       ctl_mode,
  input  logic [PTR_W-1:0] ctl_ptr,
  input  logic             dat_wr,
  input  logic             dat_rd,
  output logic [PTR_W-1:0] ptr,
  output logic             ram_rd,
  output logic             ram_we,
  output logic             rvalid
);
  host_mode_t mode;
  logic       acc;

  assign ram_we = !ctl_wr && dat_wr && mode.wr_mode;
  assign ram_rd = !ctl_wr && dat_rd && !mode.wr_mode;
  assign acc    = ram_we || ram_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode   <= '0;
      ptr    <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= ram_rd;
      if (ctl_wr) begin
        mode <= ctl_mode;
        ptr  <= ctl_ptr;
      end else if (acc && mode.step) begin
        ptr <= (ptr == PTR_W'(WORDS - 1)) ? '0 : ptr + PTR_W'(1);
      end
    end
  end

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (ptr == '0 && !rvalid && mode == '0));
  a_r2_ptr_load: assert property (@(posedge clk) disable iff (rst)
    ctl_wr |=> ptr == $past(ctl_ptr));
  a_r5_step: assert property (@(posedge clk) disable iff (rst)
    (!ctl_wr && (dat_wr || dat_rd) && mode.step && (dat_wr == mode.wr_mode || dat_rd == !mode.wr_mode))
    |=> ptr == PTR_W'(($past(ptr) + 1) % WORDS));
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (!ctl_wr && !mode.step) |=> $stable(ptr));
  a_r4_no_valid_in_write_mode: assert property (@(posedge clk) disable iff (rst)
    (mode.wr_mode && !ctl_wr) |=> !rvalid);
  a_r6_ctl_wins: assert property (@(posedge clk) disable iff (rst)
    ctl_wr |=> !rvalid);
endmodule

// File: rtl/xfer_buf_seq.sv
module xfer_buf_seq #(
  parameter int BYTES      = 512,
  parameter int WORD_BYTES = 4,
  parameter int BAW        = $clog2(BYTES),
  parameter int LW         = $clog2(WORD_BYTES)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ofs_wr,
  input  logic [BAW-1:0] ofs_wdata,
  input  logic           start,
  input  logic           rd,
  input  logic           wr,
  output logic [BAW-1:0] cursor,
  output logic           rd_acc,
  output logic           wr_acc,
  output logic [LW-1:0]  lane_q,
  output logic           rvalid
);
  logic [BAW-1:0] ofs;

  assign wr_acc = !start && wr;
  assign rd_acc = !start && rd && !wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      ofs    <= '0;
      cursor <= '0;
      lane_q <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_acc;
      if (ofs_wr) ofs <= ofs_wdata;
      if (rd_acc) lane_q <= cursor[LW-1:0];
      if (start) cursor <= ofs;
      else if (rd_acc || wr_acc) cursor <= cursor + BAW'(1);
    end
  end

  a_r1_seq_reset: assert property (@(posedge clk)
    rst |=> (cursor == '0 && ofs == '0 && !rvalid));
  a_r7_start_load: assert property (@(posedge clk) disable iff (rst)
    start |=> (cursor == $past(ofs) && !rvalid));
  a_r8_advance: assert property (@(posedge clk) disable iff (rst)
    (!start && (rd || wr)) |=> cursor == BAW'($past(cursor) + BAW'(1)));
  a_r9_write_first: assert property (@(posedge clk) disable iff (rst)
    wr |=> !rvalid);
endmodule

// File: rtl/xfer_buf.sv
module xfer_buf
  import xfer_buf_pkg::*;
#(
  parameter int BUF_BYTES  = 512,
  parameter int WORD_BYTES = 4,
  localparam int WORDS     = BUF_BYTES / WORD_BYTES,
  localparam int PTR_W     = $clog2(WORDS),
  localparam int BAW       = $clog2(BUF_BYTES),
  localparam int LW        = $clog2(WORD_BYTES),
  localparam int DW        = 8 * WORD_BYTES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_wr,
  input  logic [31:0]      ctl_wdata,
  input  logic             dat_wr,
  input  logic [DW-1:0]    dat_wdata,
  input  logic             dat_rd,
  output logic [DW-1:0]    dat_rdata,
  output logic             dat_rvalid,
  output logic [PTR_W-1:0] host_ptr,
  input  logic             seq_ofs_wr,
  input  logic [BAW-1:0]   seq_ofs,
  input  logic             seq_start,
  input  logic             seq_rd,
  output logic [7:0]       seq_rdata,
  output logic             seq_rvalid,
  input  logic             seq_wr,
  input  logic [7:0]       seq_wdata
);
  host_mode_t     ctl_mode;
  logic           h_rd, h_we;
  logic [BAW-1:0] cursor;
  logic           s_rd, s_we;
  logic [LW-1:0]  lane_q;
  logic [7:0]     lane_b [WORD_BYTES];
  logic           unused_ctl;

  assign ctl_mode   = '{wr_mode: ctl_wdata[CTL_MODE_BIT], step: ctl_wdata[CTL_STEP_BIT]};
  assign unused_ctl = ^{ctl_wdata[29:CTL_PTR_MSB+1], ctl_wdata[CTL_PTR_MSB:PTR_W]};

  xfer_buf_host #(.WORDS(WORDS), .PTR_W(PTR_W)) u_host (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_mode(ctl_mode),
    .ctl_ptr(ctl_wdata[PTR_W-1:0]), .dat_wr(dat_wr), .dat_rd(dat_rd),
    .ptr(host_ptr), .ram_rd(h_rd), .ram_we(h_we), .rvalid(dat_rvalid)
  );

  xfer_buf_seq #(.BYTES(BUF_BYTES), .WORD_BYTES(WORD_BYTES), .BAW(BAW), .LW(LW)) u_seq (
    .clk(clk), .rst(rst), .ofs_wr(seq_ofs_wr), .ofs_wdata(seq_ofs),
    .start(seq_start), .rd(seq_rd), .wr(seq_wr), .cursor(cursor),
    .rd_acc(s_rd), .wr_acc(s_we), .lane_q(lane_q), .rvalid(seq_rvalid)
  );

  // one byte-wide dual-port store per lane; lane i holds byte i of each word
  for (genvar i = 0; i < WORD_BYTES; i++) begin : g_lane
    xfer_buf_lane #(.DEPTH(WORDS), .AW(PTR_W)) u_lane (
      .clk(clk),
      .a_en(h_rd), .a_we(h_we), .a_addr(host_ptr),
      .a_din(dat_wdata[8*i +: 8]), .a_dout(dat_rdata[8*i +: 8]),
      .b_en(s_rd), .b_we(s_we && cursor[LW-1:0] == LW'(i)),
      .b_addr(cursor[BAW-1:LW]), .b_din(seq_wdata), .b_dout(lane_b[i])
    );
  end

  assign seq_rdata = lane_b[lane_q];

  a_r4_read_valid: assert property (@(posedge clk) disable iff (rst)
    (dat_rd && !ctl_wr && !ctl_mode.wr_mode && !dat_wr && h_rd) |=> dat_rvalid);
  a_r8_seq_valid: assert property (@(posedge clk) disable iff (rst)
    (seq_rd && !seq_wr && !seq_start) |=> seq_rvalid);
endmodule

// File: tb/xfer_buf_bench.sv
`timescale 1ns/1ps
module xfer_buf_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctl_wr = 0, dat_wr = 0, dat_rd = 0;
  logic [31:0] ctl_wdata = 0, dat_wdata = 0;
  logic [31:0] dat_rdata;
  logic        dat_rvalid;
  logic [6:0]  host_ptr;
  logic        seq_ofs_wr = 0, seq_start = 0, seq_rd = 0, seq_wr = 0;
  logic [8:0]  seq_ofs = 0;
  logic [7:0]  seq_wdata = 0, seq_rdata;
  logic        seq_rvalid;

  int checks = 0, errors = 0;
  logic [7:0] m [512];

  always #10 clk = ~clk;

  xfer_buf u_xfer_buf (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .dat_wr(dat_wr), .dat_wdata(dat_wdata), .dat_rd(dat_rd),
    .dat_rdata(dat_rdata), .dat_rvalid(dat_rvalid), .host_ptr(host_ptr),
    .seq_ofs_wr(seq_ofs_wr), .seq_ofs(seq_ofs), .seq_start(seq_start),
    .seq_rd(seq_rd), .seq_rdata(seq_rdata), .seq_rvalid(seq_rvalid),
    .seq_wr(seq_wr), .seq_wdata(seq_wdata)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  function automatic logic [31:0] wexp(int w);
    return {m[4*w+3], m[4*w+2], m[4*w+1], m[4*w]};
  endfunction

  task automatic ctl(bit wmode, bit stp, int p);
    ctl_wdata = {wmode, stp, 22'd0, 8'(p)}; ctl_wr = 1; step(); ctl_wr = 0;
  endtask

  task automatic hwrite(logic [31:0] w);
    dat_wdata = w; dat_wr = 1; step(); dat_wr = 0;
  endtask

  task automatic hread(output logic [31:0] d, output logic v);
    dat_rd = 1; step(); dat_rd = 0; d = dat_rdata; v = dat_rvalid;
  endtask

  task automatic sstart(int o);
    seq_ofs = 9'(o); seq_ofs_wr = 1; step(); seq_ofs_wr = 0;
    seq_start = 1; step(); seq_start = 0;
  endtask

  task automatic sread(output logic [7:0] d, output logic v);
    seq_rd = 1; step(); seq_rd = 0; d = seq_rdata; v = seq_rvalid;
  endtask

  task automatic swrite(logic [7:0] b);
    seq_wdata = b; seq_wr = 1; step(); seq_wr = 0;
  endtask

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [7:0]  b;
    logic        v;
    for (int i = 0; i < 512; i++) m[i] = 8'((i * 37 + 11) & 255);

    step(); step(); rst = 0; step();
    // R1: reset state
    check("R1 ptr", 32'(host_ptr), 0);
    check("R1 dat_rvalid", 32'(dat_rvalid), 0);
    check("R1 seq_rvalid", 32'(seq_rvalid), 0);
    // R1: reset mode is host-read, so a data write is ignored and the pointer stays
    dat_wdata = 32'hDEAD_BEEF; dat_wr = 1; step(); dat_wr = 0;
    check("R1 mode read", 32'(host_ptr), 0);

    // R2/R3/R5: fill every word by streaming, pointer wraps back to 0
    ctl(1, 1, 0);
    check("R2 ptr load", 32'(host_ptr), 0);
    for (int w = 0; w < 128; w++) hwrite(wexp(w));
    check("R5 wrap after full pass", 32'(host_ptr), 0);

    // R4/R10: stream every word back out
    ctl(0, 1, 0);
    for (int w = 0; w < 128; w++) begin
      hread(d, v);
      check("R4 rvalid", 32'(v), 1);
      check("R10 word packing", d, wexp(w));
    end
    check("R5 wrap after read pass", 32'(host_ptr), 0);

    // R3: write in read mode has no effect
    ctl(0, 1, 5);
    hwrite(32'h1234_5678);
    check("R3 ptr unmoved", 32'(host_ptr), 5);
    hread(d, v);
    check("R3 word intact", d, wexp(5));

    // R4: read in write mode ignored
    ctl(1, 1, 9);
    hread(d, v);
    check("R4 no rvalid in write mode", 32'(v), 0);
    check("R4 ptr unmoved", 32'(host_ptr), 9);

    // R2 modulo load, R5 stepping off
    ctl(1, 0, 200);
    check("R2 ptr modulo", 32'(host_ptr), 72);
    hwrite(32'hAAAA_0001);
    hwrite(32'hBBBB_0002);
    check("R5 hold", 32'(host_ptr), 72);
    {m[291], m[290], m[289], m[288]} = 32'hBBBB_0002;
    ctl(0, 0, 72);
    hread(d, v);
    check("R5 overwrite same word", d, 32'hBBBB_0002);
    hread(d, v);
    check("R5 repeat read", d, 32'hBBBB_0002);
    check("R5 hold on read", 32'(host_ptr), 72);

    // R6: control write wins over a same-cycle data write
    ctl_wdata = {1'b1, 1'b1, 22'd0, 8'd3}; ctl_wr = 1;
    dat_wdata = 32'hCAFE_F00D; dat_wr = 1;
    step(); ctl_wr = 0; dat_wr = 0;
    check("R6 ptr from ctl", 32'(host_ptr), 3);
    ctl(0, 0, 3);
    hread(d, v);
    check("R6 word untouched", d, wexp(3));

    // R8: sequencer reads every byte from offset 0, then wraps
    sstart(0);
    for (int i = 0; i < 512; i++) begin
      sread(b, v);
      check("R8 seq rvalid", 32'(v), 1);
      check("R8 seq byte", 32'(b), 32'(m[i]));
    end
    sread(b, v);
    check("R8 cursor wrap", 32'(b), 32'(m[0]));

    // R7/R8: offset near end crosses the wrap
    sstart(510);
    sread(b, v); check("R7 offset 510", 32'(b), 32'(m[510]));
    sread(b, v); check("R8 byte 511", 32'(b), 32'(m[511]));
    sread(b, v); check("R8 wrap to 0", 32'(b), 32'(m[0]));

    // R9/R11: sequencer writes six bytes at 64, partial final word
    sstart(64);
    for (int i = 0; i < 6; i++) begin
      swrite(8'(8'hC0 + i));
      m[64 + i] = 8'(8'hC0 + i);
    end
    // R9: write and read together, write wins and no read valid
    seq_wdata = 8'h5A; seq_wr = 1; seq_rd = 1; step(); seq_wr = 0; seq_rd = 0;
    check("R9 read dropped", 32'(seq_rvalid), 0);
    m[70] = 8'h5A;
    ctl(0, 1, 16);
    hread(d, v); check("R9 full word 16", d, wexp(16));
    hread(d, v); check("R11 partial word 17", d, wexp(17));

    // R7: start with same-cycle read drops the read
    sstart(0);
    seq_ofs = 9'd0; seq_start = 1; seq_rd = 1; step(); seq_start = 0; seq_rd = 0;
    check("R7 access dropped at start", 32'(seq_rvalid), 0);
    sread(b, v);
    check("R7 cursor at offset", 32'(b), 32'(m[0]));

    // R12: host and sequencer write the same byte together
    ctl(1, 0, 20);
    sstart(81);
    dat_wdata = 32'h7766_5544; dat_wr = 1; seq_wdata = 8'hEE; seq_wr = 1;
    step(); dat_wr = 0; seq_wr = 0;
    ctl(0, 0, 20);
    hread(d, v);
    check("R12 host wins", d, 32'h7766_5544);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule